// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is a host-side configuration port that takes up two adjacent I/O addresses. The lower address is the index port and the one above it is the data port. Configuration space is hidden after reset. Software opens it by writing the unlock key twice in a row to the index port and closes it again with a single lock key. While the port is open, a write to the index port picks a configuration register, and a read or write of the data port then reaches that register.

Registers up to 0x2F are global. They hold a logical-device select, a device identifier, a revision byte and a manufacturer identifier. Registers from 0x30 upward are banked. They are forwarded over a register-access port to the logical device whose number sits in the select register. When no device claims the access, a read returns 0xFF. A strap input moves the port pair between two base addresses.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the index register holds 0x00 and the logical-device select holds 0x00.
- R2: The port opens only when two index-port writes of 0x87 follow each other with no other index-port write between them. Data-port accesses between the two keys do not break the sequence. Any other index value written between them restarts the sequence.
- R3: While the port is open, writing 0xAA to the index port locks it and leaves the index register unchanged.
- R4: While the port is locked, data-port writes have no effect, index-port writes other than the key do not change the index register, and reads of either port return 0xFF.
- R5: While the port is open, an index-port write other than 0xAA loads the index register, and an index-port read returns that register.
- R6: Register 0x07 is the logical-device select. It is read and written through the data port.
- R7: Registers 0x20/0x21 return the device identifier high byte then low byte (default 0x0A51). Register 0x22 returns the revision (default 0x03). Registers 0x23/0x24 return the manufacturer identifier 0x19 then 0x34.
- R8: All other global registers (0x00 to 0x2F) read as 0x00. Writes to them, and to the identifier registers, have no effect.
- R9: With the port open and the index at 0x30 or above, a data-port write pulses ldWr and a data-port read pulses ldRd, in the same cycle, with ldIdx, ldSel and ldWrData valid. The read returns ldRdData when ldHit is high and 0xFF otherwise.
- R10: Accesses to global registers never pulse ldWr or ldRd.
- R11: With strapAlt low the ports sit at 0x2E/0x2F, and with strapAlt high at 0x4E/0x4F. Accesses to any other address are ignored.
- R12: ioRdData is combinational. It is 0xFF in any cycle without a read of an open port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAlt | input | 1 | Selects the alternate base address |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | I/O write strobe, one cycle |
| ioRd | input | 1 | I/O read strobe, one cycle |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data, valid in the cycle of ioRd |
| ldSel | output | 8 | Selected logical-device number |
| ldIdx | output | 8 | Register index for the logical device |
| ldWrData | output | 8 | Write data for the logical device |
| ldWr | output | 1 | Forwarded write strobe |
| ldRd | output | 1 | Forwarded read strobe |
| ldRdData | input | 8 | Read data from the logical device |
| ldHit | input | 1 | A logical device claims the current access |

## Verification
The bench builds the block with its default parameters: bases 0x2E and 0x4E, unlock key 0x87, lock key 0xAA, global range up to 0x2F and the default identifier bytes. It toggles strapAlt, so both address pairs and the ignoring of the inactive pair are covered. A bench device answers only on logical device 0x06. This covers forwarded hits, the 0xFF miss response and the routing of each access by the select register. Broken and interleaved key sequences check that only consecutive index-port keys open the port.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef logic [7:0] cfgByte_t;

  // Strobes from the key/decode control to the register datapath.
  typedef struct packed {
    logic idxWr;   // load index register
    logic dataWr;  // data-port write while open
    logic idxRd;   // index-port read while open
    logic dataRd;  // data-port read while open
    logic open;    // configuration space visible
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 'h4E,
  parameter cfgByte_t KEY_UNLOCK = 8'h87,
  parameter cfgByte_t KEY_LOCK = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapAlt,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  cfgByte_t          ioWrData,
  output cfgStrobe_t        strb
);
  typedef enum logic [1:0] {ST_LOCKED, ST_HALF, ST_OPEN} keyState_t;

  keyState_t stateQ, stateD;
  logic [ADDR_W-1:0] basePick;
  logic idxHit, dataHit, idxWrite;

  assign basePick = strapAlt ? BASE_ALT : BASE_PRI;
  assign idxHit   = (ioAddr == basePick);
  assign dataHit  = (ioAddr == basePick + ADDR_W'(1));
  assign idxWrite = ioWr && idxHit;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_LOCKED: if (idxWrite && ioWrData == KEY_UNLOCK) stateD = ST_HALF;
      ST_HALF: begin
        if (idxWrite) stateD = (ioWrData == KEY_UNLOCK) ? ST_OPEN : ST_LOCKED;
      end
      ST_OPEN:   if (idxWrite && ioWrData == KEY_LOCK) stateD = ST_LOCKED;
      default:   stateD = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_LOCKED;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.open   = (stateQ == ST_OPEN);
    strb.idxWr  = strb.open && idxWrite && (ioWrData != KEY_LOCK);
    strb.dataWr = strb.open && ioWr && dataHit;
    strb.idxRd  = strb.open && ioRd && idxHit;
    strb.dataRd = strb.open && ioRd && dataHit;
  end
endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfg_port_pkg::*;
#(
  parameter cfgByte_t LDN_REG = 8'h07,
  parameter cfgByte_t GLOBAL_TOP = 8'h2F,
  parameter cfgByte_t ID_BASE = 8'h20,
  parameter logic [15:0] DEV_ID = 16'h0A51,
  parameter cfgByte_t DEV_REV = 8'h03,
  parameter logic [15:0] MFR_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strb,
  input  cfgByte_t   ioWrData,
  output cfgByte_t   ioRdData,
  output cfgByte_t   ldSel,
  output cfgByte_t   ldIdx,
  output cfgByte_t   ldWrData,
  output logic       ldWr,
  output logic       ldRd,
  input  cfgByte_t   ldRdData,
  input  logic       ldHit
);
  localparam int ID_BYTES = 5;
  localparam int ID_SLOTS = 8;
  localparam logic [8*ID_BYTES-1:0] ID_PACK = {DEV_ID, DEV_REV, MFR_ID};

  cfgByte_t idxQ, ldnQ, idOff, globalRd;
  cfgByte_t idTable [ID_SLOTS];
  logic isGlobal, inId;

  // Identification bytes, highest byte of the packed word first.
  for (genvar g = 0; g < ID_SLOTS; g++) begin : gId
    if (g < ID_BYTES) begin : gLive
      assign idTable[g] = ID_PACK[8*(ID_BYTES-g)-1 -: 8];
    end else begin : gPad
      assign idTable[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      ldnQ <= '0;
    end else begin
      if (strb.idxWr) idxQ <= ioWrData;
      if (strb.dataWr && idxQ == LDN_REG) ldnQ <= ioWrData;
    end
  end

  assign isGlobal = (idxQ <= GLOBAL_TOP);
  assign idOff    = idxQ - ID_BASE;
  assign inId     = (idxQ >= ID_BASE) && (idOff < 8'(ID_BYTES));

  always_comb begin
    if (idxQ == LDN_REG) globalRd = ldnQ;
    else if (inId)       globalRd = idTable[idOff[2:0]];
    else                 globalRd = '0;
  end

  always_comb begin
    if (strb.idxRd)       ioRdData = idxQ;
    else if (strb.dataRd) ioRdData = isGlobal ? globalRd : (ldHit ? ldRdData : 8'hFF);
    else                  ioRdData = 8'hFF;
  end

  assign ldWr     = strb.dataWr && !isGlobal;
  assign ldRd     = strb.dataRd && !isGlobal;
  assign ldIdx    = idxQ;
  assign ldSel    = ldnQ;
  assign ldWrData = ioWrData;
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 'h4E,
  parameter logic [7:0] KEY_UNLOCK = 8'h87,
  parameter logic [7:0] KEY_LOCK = 8'hAA,
  parameter logic [7:0] LDN_REG = 8'h07,
  parameter logic [7:0] GLOBAL_TOP = 8'h2F,
  parameter logic [7:0] ID_BASE = 8'h20,
  parameter logic [15:0] DEV_ID = 16'h0A51,
  parameter logic [7:0] DEV_REV = 8'h03,
  parameter logic [15:0] MFR_ID = 16'h1934
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapAlt,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic [7:0]        ldSel,
  output logic [7:0]        ldIdx,
  output logic [7:0]        ldWrData,
  output logic              ldWr,
  output logic              ldRd,
  input  logic [7:0]        ldRdData,
  input  logic              ldHit
);
  cfgStrobe_t strb;

  cfg_port_ctrl #(
    .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT),
    .KEY_UNLOCK(KEY_UNLOCK), .KEY_LOCK(KEY_LOCK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .strapAlt(strapAlt), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData), .strb(strb)
  );

  cfg_port_dp #(
    .LDN_REG(LDN_REG), .GLOBAL_TOP(GLOBAL_TOP), .ID_BASE(ID_BASE),
    .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MFR_ID(MFR_ID)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .ldSel(ldSel), .ldIdx(ldIdx), .ldWrData(ldWrData),
    .ldWr(ldWr), .ldRd(ldRd), .ldRdData(ldRdData), .ldHit(ldHit)
  );
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 'h4E,
  parameter logic [7:0] KEY_UNLOCK = 8'h87,
  parameter logic [7:0] KEY_LOCK = 8'hAA,
  parameter logic [7:0] GLOBAL_TOP = 8'h2F
) (
  input logic              clk,
  input logic              rstN,
  input logic              strapAlt,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [7:0]        ioWrData,
  input logic [7:0]        ioRdData,
  input logic [7:0]        ldSel,
  input logic [7:0]        ldIdx,
  input logic              ldWr,
  input logic              ldRd,
  input logic              portOpen
);
  logic [ADDR_W-1:0] idxAddr;
  assign idxAddr = strapAlt ? BASE_ALT : BASE_PRI;

  // R1: port is locked in the first cycle after reset
  assert_reset_locked_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !portOpen);

  // R2: opening is always caused by an unlock key on the index port
  assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portOpen) |-> ($past(ioWr) && $past(ioWrData) == KEY_UNLOCK && $past(ioAddr) == $past(idxAddr)));

  // R3: lock key closes the port on the next cycle
  assert_lock_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    (portOpen && ioWr && ioAddr == idxAddr && ioWrData == KEY_LOCK) |=> !portOpen);

  // R4: a locked port reads 0xFF on the data port
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!portOpen && ioRd && ioAddr == idxAddr + ADDR_W'(1)) |-> ioRdData == 8'hFF);

  // R6: the device select cannot move while locked
  assert_ldn_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !portOpen |=> $stable(ldSel));

  // R9: forwarded strobes only while open
  assert_fwd_open_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ldWr || ldRd) |-> portOpen);

  // R10: forwarded strobes never carry a global index
  assert_fwd_upper_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ldWr || ldRd) |-> ldIdx > GLOBAL_TOP);

  // R12: no read strobe means the idle value
  assert_idle_ff_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> ioRdData == 8'hFF);
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT),
  .KEY_UNLOCK(KEY_UNLOCK), .KEY_LOCK(KEY_LOCK), .GLOBAL_TOP(GLOBAL_TOP)
) uChk (
  .clk(clk), .rstN(rstN), .strapAlt(strapAlt), .ioAddr(ioAddr),
  .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData), .ioRdData(ioRdData),
  .ldSel(ldSel), .ldIdx(ldIdx), .ldWr(ldWr), .ldRd(ldRd),
  .portOpen(strb.open)
);

// File: tb/sim_keyed_cfg_port.sv
`timescale 1ns/100ps
module sim_keyed_cfg_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapAlt = 1'b0;
  logic [15:0] ioAddr = '0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData, ldSel, ldIdx, ldWrData, ldRdData;
  logic ldWr, ldRd, ldHit;

  always #2.5 clk = ~clk;

  keyed_cfg_port u0 (
    .clk(clk), .rstN(rstN), .strapAlt(strapAlt), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .ldSel(ldSel), .ldIdx(ldIdx), .ldWrData(ldWrData), .ldWr(ldWr),
    .ldRd(ldRd), .ldRdData(ldRdData), .ldHit(ldHit)
  );

  // Bench logical device: answers only as device 0x06.
  logic [7:0] devMem [256];
  assign ldHit    = (ldSel == 8'h06);
  assign ldRdData = devMem[ldIdx];

  int checks = 0, failures = 0, ldWrCount = 0;
  string curReq = "R1";

  // Behavioural reference state.
  int mState = 0;  // 0 locked, 1 one key seen, 2 open
  int mIdx = 0, mLdn = 0;

  function automatic int baseAddr();
    return strapAlt ? 'h4E : 'h2E;
  endfunction

  function automatic int globalExp(int idx);
    case (idx)
      7: return mLdn;
      'h20: return 'h0A;
      'h21: return 'h51;
      'h22: return 'h03;
      'h23: return 'h19;
      'h24: return 'h34;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) devMem[i] = 8'(i ^ 'hA5);
  end

  // Model update and bench device write at the clock edge.
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mLdn = 0;
    end else begin
      automatic bit idxW = ioWr && (int'(ioAddr) == baseAddr());
      automatic bit datW = ioWr && (int'(ioAddr) == baseAddr() + 1);
      automatic int d = int'(ioWrData);
      if (ldWr) begin
        ldWrCount++;
        if (ldSel == 8'h06) devMem[ldIdx] <= ldWrData;
      end
      if (mState == 2) begin
        if (datW && mIdx == 7) mLdn = d;
        if (idxW) begin
          if (d == 'hAA) mState = 0;
          else mIdx = d;
        end
      end else if (idxW) begin
        if (d == 'h87) mState = (mState == 1) ? 2 : 1;
        else mState = 0;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      automatic bit open = (mState == 2);
      automatic bit idxA = (int'(ioAddr) == baseAddr());
      automatic bit datA = (int'(ioAddr) == baseAddr() + 1);
      automatic int expRd = 'hFF;
      automatic bit expWr = open && ioWr && datA && mIdx >= 'h30;
      automatic bit expRdS = open && ioRd && datA && mIdx >= 'h30;
      if (ioRd && open && idxA) expRd = mIdx;
      else if (ioRd && open && datA)
        expRd = (mIdx <= 'h2F) ? globalExp(mIdx) : ((mLdn == 6) ? int'(devMem[mIdx]) : 'hFF);
      check(int'(ioRdData) == expRd, {curReq, "/R12 rd"}, ioRdData, expRd);
      check(ldWr == expWr, {curReq, "/R10 ldWr"}, ldWr, expWr);
      check(ldRd == expRdS, {curReq, "/R10 ldRd"}, ldRd, expRdS);
      if (expWr || expRdS)
        check(int'(ldIdx) == mIdx && int'(ldSel) == mLdn && ldWrData == ioWrData,
              {curReq, "/R9 fwd"}, {ldSel, ldIdx}, (mLdn << 8) | mIdx);
    end
  end

  task automatic wrIo(int addr, int data);
    @(negedge clk);
    ioAddr = 16'(addr); ioWrData = 8'(data); ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic rdIo(int addr, int exp, string req);
    @(negedge clk);
    ioAddr = 16'(addr); ioRd = 1'b1;
    #1.5;
    check(int'(ioRdData) == exp, req, ioRdData, exp);
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic setReg(int idx, int data);
    wrIo(baseAddr(), idx);
    wrIo(baseAddr() + 1, data);
  endtask

  task automatic rdReg(int idx, int exp, string req);
    wrIo(baseAddr(), idx);
    rdIo(baseAddr() + 1, exp, req);
  endtask

  task automatic unlock();
    wrIo(baseAddr(), 'h87);
    wrIo(baseAddr(), 'h87);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: locked after reset, index and select at zero
    curReq = "R1";
    rdIo('h2F, 'hFF, "R1 locked data read");
    check(ioRdData == 8'hFF, "R12 idle", ioRdData, 'hFF);
    unlock();
    rdIo('h2E, 'h00, "R1 index reset");
    wrIo('h2F, 'h00);            // data write to reg 0: no effect
    rdReg('h07, 'h00, "R1 select reset");
    // R7: identification bytes
    curReq = "R7";
    rdReg('h20, 'h0A, "R7 devid hi");
    rdReg('h21, 'h51, "R7 devid lo");
    rdReg('h22, 'h03, "R7 rev");
    rdReg('h23, 'h19, "R7 mfr hi");
    rdReg('h24, 'h34, "R7 mfr lo");
    // R5: index readback
    curReq = "R5";
    wrIo('h2E, 'h5C);
    rdIo('h2E, 'h5C, "R5 index readback");
    // R6: device select
    curReq = "R6";
    setReg('h07, 'h06);
    rdReg('h07, 'h06, "R6 select readback");
    // R9: forwarding to device 6
    curReq = "R9";
    setReg('hF0, 'h5A);
    rdIo('h2F, 'h5A, "R9 forwarded read hit");
    rdReg('h30, 'h30 ^ 'hA5, "R9 lowest banked register");
    setReg('h07, 'h03);
    rdReg('hF0, 'hFF, "R9 no device answers");
    setReg('h07, 'h06);
    // R8/R10: global writes ignored and never forwarded
    curReq = "R10";
    snap = ldWrCount;
    setReg('h20, 'h00);
    setReg('h10, 'h55);
    setReg('h2F, 'h77);
    check(ldWrCount == snap, "R10 global writes not forwarded", ldWrCount, snap);
    curReq = "R8";
    rdReg('h20, 'h0A, "R8 id write ignored");
    rdReg('h10, 'h00, "R8 spare global reads zero");
    rdReg('h2F, 'h00, "R8 top global reads zero");
    // R3: lock key
    curReq = "R3";
    wrIo('h2E, 'h07);
    wrIo('h2E, 'hAA);
    rdIo('h2F, 'hFF, "R3 locked after key");
    rdIo('h2E, 'hFF, "R4 locked index read");
    // R4: locked writes ignored
    curReq = "R4";
    snap = ldWrCount;
    wrIo('h2E, 'h31);
    wrIo('h2F, 'h09);
    check(ldWrCount == snap, "R4 locked data write not forwarded", ldWrCount, snap);
    unlock();
    rdIo('h2E, 'h07, "R3/R4 index kept over lock and locked write");
    rdIo('h2F, 'h06, "R4 select unchanged by locked write");
    // R2: broken key sequence
    curReq = "R2";
    wrIo('h2E, 'hAA);
    wrIo('h2E, 'h87);
    wrIo('h2E, 'h12);
    wrIo('h2E, 'h87);
    rdIo('h2F, 'hFF, "R2 broken sequence stays locked");
    wrIo('h2E, 'h87);
    rdIo('h2E, 'h07, "R2 consecutive keys open");
    wrIo('h2E, 'hAA);
    wrIo('h2E, 'h87);
    wrIo('h2F, 'h33);
    rdIo('h2F, 'hFF, "R2 still locked after one key");
    wrIo('h2E, 'h87);
    rdIo('h2E, 'h07, "R2 data access does not break keys");
    // R11: strap moves the port
    curReq = "R11";
    strapAlt = 1'b1;
    rdIo('h2F, 'hFF, "R11 old pair ignored");
    wrIo('h2E, 'h22);
    rdIo('h4E, 'h07, "R11 old index write ignored");
    rdReg('h22, 'h03, "R11 alternate pair works");
    wrIo('h4E, 'hAA);
    rdIo('h4F, 'hFF, "R11 lock on alternate pair");
    strapAlt = 1'b0;
    rdIo('h2F, 'hFF, "R11 back to primary, locked");
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule